// File: doc/BRIEF.md
# Boot Bank Mirroring Select

This block picks which physical static-memory bank answers to the processor's boot bank (chip select 0). Bank 0 can alias one of two banks. One is the on-board boot bank (bank 1). The other is bank 2 on a plug-in expansion card. An active-low boot strap on the card makes the choice. A card-enable control bit qualifies the strap.

The choice is taken only when a power-up or push-button reset ends, or when the processor leaves sleep. The choice is held through software and watchdog resets. When the card supplies the boot bank, the boot-width select comes from a card width strap. Otherwise it comes from a fixed on-board width. The block also routes the processor chip selects to the card and board banks. All chip selects are active low, and every output is registered.

Top module: `boot_mirror_sel`

## Requirements
- R1: After the synchronous reset `rst`, `mirror_card` is 0 (on-board source), `boot_wide` equals parameter BOARD_WIDE (1 = 32-bit, 0 = 16-bit), and `board_cs1_n`, `card_cs2_n` and `card_cs3_n` are all 1.
- R2: At the first clock edge that samples `hard_rst` low after sampling it high, `mirror_card` becomes 1 if `card_boot_n` is 0 and becomes 0 otherwise. The value of `card_en` has no effect on this choice.
- R3: At the first clock edge that samples `sleep_on` low after sampling it high, `mirror_card` becomes 1 only if `card_boot_n` is 0 and `card_en` is 1. Otherwise it becomes 0. If a hard-reset release falls on the same edge, R2 takes priority.
- R4: The end of `soft_rst` or `wdog_rst` does not change `mirror_card` or `boot_wide`. Changes on `card_boot_n`, `card_wide` or `card_en` outside an R2 or R3 edge do not change them either.
- R5: One cycle after the inputs are sampled, `card_cs2_n` is 0 exactly when all of the following hold: `card_en` is 1, no reset or sleep input is high, and either `cs2_n` is 0 or (`cs0_n` is 0 and `mirror_card` is 1).
- R6: One cycle after the inputs are sampled, `board_cs1_n` is 0 exactly when `cs0_n` is 0, `mirror_card` is 0, and no reset or sleep input is high.
- R7: At each R2 or R3 edge, `boot_wide` takes `card_wide` if the card was chosen, or BOARD_WIDE if the board was chosen. Here 1 means 32-bit and 0 means 16-bit.
- R8: One cycle after the inputs are sampled, `card_cs3_n` equals `cs3_n` while no reset or sleep input is high.
- R9: While any of `hard_rst`, `soft_rst`, `wdog_rst` or `sleep_on` is sampled high, the next values of all three chip-select outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| cs0_n | input | 1 | Processor boot-bank chip select, active low |
| cs2_n | input | 1 | Processor bank 2 chip select, active low |
| cs3_n | input | 1 | Processor bank 3 chip select, active low |
| hard_rst | input | 1 | Power-up or push-button reset active, high |
| soft_rst | input | 1 | Software reset active, high |
| wdog_rst | input | 1 | Watchdog reset active, high |
| sleep_on | input | 1 | Processor in sleep, high |
| card_boot_n | input | 1 | Card boot strap, 0 = boot from card |
| card_wide | input | 1 | Card bank width strap, 1 = 32-bit |
| card_en | input | 1 | Card-enable control bit |
| mirror_card | output | 1 | Latched source: 1 = bank 0 aliases card bank 2 |
| board_cs1_n | output | 1 | On-board bank chip select, active low |
| card_cs2_n | output | 1 | Card bank 2 chip select, active low |
| card_cs3_n | output | 1 | Card bank 3 chip select, active low |
| boot_wide | output | 1 | Boot bank width select, 1 = 32-bit |

## Verification
The assertions check five rules on every cycle:
- the card bank 2 select stays inactive while the card is disabled;
- all selects stay quiet during any reset or sleep;
- the bank 3 select passes straight through;
- the board select only appears with the board as source;
- the boot width tracks the source.

They also check that a hard-reset release picks the strap value. Only the bench scenarios can show which reset kinds resample the strap and which keep the old choice. The same holds for the card-enable qualification on sleep exit and for hard-reset priority when two releases coincide. The behavioural model confirms these across random chip-select traffic and random event sequences.

// File: rtl/bmirror_pkg.sv
package bmirror_pkg;
  typedef enum logic {
    SRC_BOARD = 1'b0,
    SRC_CARD  = 1'b1
  } boot_src_e;

  typedef struct packed {
    logic cs0_n;
    logic cs2_n;
    logic cs3_n;
  } cpu_cs_t;

  localparam int EVT_HARD    = 0;
  localparam int EVT_SLEEP   = 1;
  localparam int N_LATCH_EVT = 2;
endpackage

// File: rtl/evt_fall_det.sv
module evt_fall_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b0;
      else     prev_q[i] <= lvl[i];
    end
    assign fall[i] = prev_q[i] & ~lvl[i];
  end
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import bmirror_pkg::*;
#(
  parameter logic BOARD_WIDE = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_LATCH_EVT-1:0] fall,
  input  logic                   card_boot_n,
  input  logic                   card_wide,
  input  logic                   card_en,
  output logic                   mirror_d,
  output logic                   mirror_q,
  output logic                   wide_q
);
  logic take;
  logic pick_card;
  logic wide_d;

  // A hard-reset release forces the enable to 1, so the strap decides alone.
  assign take      = |fall;
  assign pick_card = ~card_boot_n & (fall[EVT_HARD] | card_en);
  assign mirror_d  = take ? pick_card : mirror_q;
  assign wide_d    = take ? (pick_card ? card_wide : BOARD_WIDE) : wide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mirror_q <= SRC_BOARD;
      wide_q   <= BOARD_WIDE;
    end else begin
      mirror_q <= mirror_d;
      wide_q   <= wide_d;
    end
  end

  p_hard_pick_r2: assert property (@(posedge clk) disable iff (rst)
    fall[EVT_HARD] |=> (mirror_q == !$past(card_boot_n)));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(|fall) |=> ($stable(mirror_q) && $stable(wide_q)));

  p_board_width_r7: assert property (@(posedge clk) disable iff (rst)
    (mirror_q == SRC_BOARD) |-> (wide_q == BOARD_WIDE));
endmodule

// File: rtl/cs_route.sv
module cs_route
  import bmirror_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  cpu_cs_t cs,
  input  logic    quiet,
  input  logic    card_en,
  input  logic    mirror,
  output logic    board_cs1_n,
  output logic    card_cs2_n,
  output logic    card_cs3_n
);
  logic b1_d, c2_d, c3_d;

  assign b1_d = ~(quiet & ~cs.cs0_n & (mirror == SRC_BOARD));
  assign c2_d = ~(card_en & quiet & (~cs.cs2_n | (~cs.cs0_n & (mirror == SRC_CARD))));
  assign c3_d = ~(quiet & ~cs.cs3_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      board_cs1_n <= 1'b1;
      card_cs2_n  <= 1'b1;
      card_cs3_n  <= 1'b1;
    end else begin
      board_cs1_n <= b1_d;
      card_cs2_n  <= c2_d;
      card_cs3_n  <= c3_d;
    end
  end

  p_card_off_r5: assert property (@(posedge clk) disable iff (rst)
    !card_en |=> card_cs2_n);

  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !quiet |=> (card_cs2_n && board_cs1_n && card_cs3_n));

  p_pass3_r8: assert property (@(posedge clk) disable iff (rst)
    quiet |=> (card_cs3_n == $past(cs.cs3_n)));
endmodule

// File: rtl/boot_mirror_sel.sv
module boot_mirror_sel
  import bmirror_pkg::*;
#(
  parameter logic BOARD_WIDE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic cs0_n,
  input  logic cs2_n,
  input  logic cs3_n,
  input  logic hard_rst,
  input  logic soft_rst,
  input  logic wdog_rst,
  input  logic sleep_on,
  input  logic card_boot_n,
  input  logic card_wide,
  input  logic card_en,
  output logic mirror_card,
  output logic board_cs1_n,
  output logic card_cs2_n,
  output logic card_cs3_n,
  output logic boot_wide
);
  logic [N_LATCH_EVT-1:0] evt_lvl;
  logic [N_LATCH_EVT-1:0] evt_fall;
  logic                   mirror_d;
  logic                   quiet;
  cpu_cs_t                cs;

  assign evt_lvl[EVT_HARD]  = hard_rst;
  assign evt_lvl[EVT_SLEEP] = sleep_on;
  assign quiet = ~(hard_rst | soft_rst | wdog_rst | sleep_on);
  assign cs    = '{cs0_n: cs0_n, cs2_n: cs2_n, cs3_n: cs3_n};

  evt_fall_det #(.W(N_LATCH_EVT)) u_fall (
    .clk  (clk),
    .rst  (rst),
    .lvl  (evt_lvl),
    .fall (evt_fall)
  );

  strap_latch #(.BOARD_WIDE(BOARD_WIDE)) u_latch (
    .clk         (clk),
    .rst         (rst),
    .fall        (evt_fall),
    .card_boot_n (card_boot_n),
    .card_wide   (card_wide),
    .card_en     (card_en),
    .mirror_d    (mirror_d),
    .mirror_q    (mirror_card),
    .wide_q      (boot_wide)
  );

  cs_route u_route (
    .clk         (clk),
    .rst         (rst),
    .cs          (cs),
    .quiet       (quiet),
    .card_en     (card_en),
    .mirror      (mirror_d),
    .board_cs1_n (board_cs1_n),
    .card_cs2_n  (card_cs2_n),
    .card_cs3_n  (card_cs3_n)
  );

  p_board_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !board_cs1_n |-> !mirror_card);
endmodule

// File: tb/sim_boot_mirror_sel.sv
`timescale 1ns/1ps
module sim_boot_mirror_sel;
  localparam logic BW = 1'b1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs0_n = 1, cs2_n = 1, cs3_n = 1;
  logic hard_rst = 0, soft_rst = 0, wdog_rst = 0, sleep_on = 0;
  logic card_boot_n = 1, card_wide = 1, card_en = 1;
  logic mirror_card, board_cs1_n, card_cs2_n, card_cs3_n, boot_wide;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;

  boot_mirror_sel #(.BOARD_WIDE(BW)) u0 (
    .clk(clk), .rst(rst), .cs0_n(cs0_n), .cs2_n(cs2_n), .cs3_n(cs3_n),
    .hard_rst(hard_rst), .soft_rst(soft_rst), .wdog_rst(wdog_rst),
    .sleep_on(sleep_on), .card_boot_n(card_boot_n), .card_wide(card_wide),
    .card_en(card_en), .mirror_card(mirror_card), .board_cs1_n(board_cs1_n),
    .card_cs2_n(card_cs2_n), .card_cs3_n(card_cs3_n), .boot_wide(boot_wide)
  );

  // Behavioural reference: state after each edge, from the requirements.
  bit m_mir, m_wide, m_c1, m_c2, m_c3, ph, ps;
  always @(posedge clk) begin
    bit hf, sf, calm;
    started = 1;
    if (rst) begin
      m_mir = 0; m_wide = BW; m_c1 = 1; m_c2 = 1; m_c3 = 1; ph = 0; ps = 0;
    end else begin
      hf = ph && !hard_rst;
      sf = ps && !sleep_on;
      if (hf) begin
        m_mir = !card_boot_n;
        m_wide = m_mir ? card_wide : BW;
      end else if (sf) begin
        m_mir = !card_boot_n && card_en;
        m_wide = m_mir ? card_wide : BW;
      end
      calm = !(hard_rst || soft_rst || wdog_rst || sleep_on);
      m_c2 = !(card_en && calm && (!cs2_n || (!cs0_n && m_mir)));
      m_c1 = !(calm && !cs0_n && !m_mir);
      m_c3 = !(calm && !cs3_n);
      ph = hard_rst;
      ps = sleep_on;
    end
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b t=%0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(mirror_card, m_mir,  "R2/R3/R4 mirror_card");
      chk(boot_wide,   m_wide, "R7 boot_wide");
      chk(card_cs2_n,  m_c2,   "R5 card_cs2_n");
      chk(board_cs1_n, m_c1,   "R6 board_cs1_n");
      chk(card_cs3_n,  m_c3,   "R8 card_cs3_n");
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    tick(3);
    // R1 reset state
    chk(mirror_card, 0, "R1 mirror"); chk(boot_wide, BW, "R1 width");
    chk(card_cs2_n, 1, "R1 cs2"); chk(board_cs1_n, 1, "R1 cs1"); chk(card_cs3_n, 1, "R1 cs3");
    rst = 0;
    tick(2);

    // R2: hard reset with strap 0 and enable 0 still picks the card
    card_en = 0; card_boot_n = 0; card_wide = 0; hard_rst = 1;
    tick(1);
    cs0_n = 0;
    tick(1);
    chk(board_cs1_n, 1, "R9 board quiet in reset");
    tick(1);
    hard_rst = 0;
    tick(1);
    chk(mirror_card, 1, "R2 hard picks card"); chk(boot_wide, 0, "R7 card width 16");
    chk(card_cs2_n, 1, "R5 disabled card cs2");
    card_en = 1;
    tick(2);
    chk(card_cs2_n, 0, "R5 cs0 routed to card"); chk(board_cs1_n, 1, "R6 board idle");
    cs0_n = 1; card_boot_n = 1; card_wide = 1;

    // R4: software and watchdog resets keep the choice
    soft_rst = 1; tick(3); soft_rst = 0; tick(2);
    chk(mirror_card, 1, "R4 soft keeps"); chk(boot_wide, 0, "R4 soft width");
    wdog_rst = 1; tick(3); wdog_rst = 0; tick(2);
    chk(mirror_card, 1, "R4 wdog keeps");

    // R3: sleep exit with strap 1 returns to board
    sleep_on = 1; tick(3); sleep_on = 0; tick(1);
    chk(mirror_card, 0, "R3 sleep strap1"); chk(boot_wide, BW, "R7 board width");
    cs0_n = 0; tick(2);
    chk(board_cs1_n, 0, "R6 board selected"); chk(card_cs2_n, 1, "R5 card idle");
    cs0_n = 1;

    // R3: strap 0 but enable 0 stays on board
    card_boot_n = 0; card_en = 0; sleep_on = 1; tick(3); sleep_on = 0; tick(1);
    chk(mirror_card, 0, "R3 sleep disabled");
    card_en = 1; sleep_on = 1; tick(3); sleep_on = 0; tick(1);
    chk(mirror_card, 1, "R3 sleep card");

    // R3: simultaneous releases, hard reset wins with enable 0
    card_en = 0; hard_rst = 1; sleep_on = 1; tick(2);
    hard_rst = 0; sleep_on = 0; tick(1);
    chk(mirror_card, 1, "R3 hard priority");
    card_en = 1; card_boot_n = 1;

    // R8 pass-through
    cs3_n = 0; tick(2); chk(card_cs3_n, 0, "R8 cs3 low");
    cs3_n = 1; tick(1); chk(card_cs3_n, 1, "R8 cs3 high");

    // random traffic and events
    for (int i = 0; i < 3000; i++) begin
      cs0_n = $urandom_range(0, 1);
      cs2_n = $urandom_range(0, 1);
      cs3_n = $urandom_range(0, 1);
      if ($urandom_range(0, 15) == 0) card_en = $urandom_range(0, 1);
      if ($urandom_range(0, 7) == 0) card_boot_n = $urandom_range(0, 1);
      if ($urandom_range(0, 7) == 0) card_wide = $urandom_range(0, 1);
      if ($urandom_range(0, 30) == 0) begin
        case ($urandom_range(0, 3))
          0: hard_rst = 1;
          1: soft_rst = 1;
          2: wdog_rst = 1;
          default: sleep_on = 1;
        endcase
      end else if ($urandom_range(0, 3) == 0) begin
        hard_rst = 0; soft_rst = 0; wdog_rst = 0; sleep_on = 0;
      end
      tick(1);
    end
    tick(2);
    summary();
  end
endmodule